// File: doc/BRIEF.md
# Pseudo-Random Test Pattern Generator with Zero-State Insertion

This block is a parameterised n-bit linear feedback shift register used to drive the inputs of logic under self-test. The feedback taps come from a characteristic polynomial parameter. A style parameter selects one of two forms. In the external form, one parity of the tapped bits feeds the first flip-flop. In the internal form, the last bit is XORed into the tapped positions as it shifts.

With a primitive polynomial the plain register visits every non-zero state and then repeats, so its period is 2^n-1. An optional correction adds the all-zeros word to the cycle, which makes the period 2^n. The correction is one NOR over the low n-1 bits and one XOR into the feedback. A second output biases the bit probabilities. It folds fixed groups of adjacent bits through AND gates, which make a 1 rare, or through OR gates, which make a 0 rare.

Reset loads a seed parameter. The register advances only on cycles where the step enable is high.

Top module: `tpg_lfsr_top`

## Requirements
- R1: While reset is high, and on the first edge after it falls, the pattern equals the SEED parameter, even if reset is raised in the middle of a run.
- R2: On a clock edge with the step enable low, the pattern and the weighted outputs keep their values.
- R3: Internal form: bit i of POLY is the coefficient of x^i, and the x^n and x^0 terms are implied. With f = s[n-1] XOR z, the next state is s'[0] = f, and for i >= 1, s'[i] = s[i-1] XOR (POLY[i] AND f).
- R4: External form: f = z XOR s[n-1] XOR (the XOR of s[i-1] for every i in 1..n-1 with POLY[i] = 1). The register shifts up, with s'[i] = s[i-1] and s'[0] = f.
- R5: When ZERO_INS = 1, z = NOR(s[n-2:0]); otherwise z = 0. With insertion the state with only s[n-1] set is followed by all-zeros, and all-zeros is followed by the state that a non-zero feedback of 1 would give. The period is 2^n, and every state appears exactly once in it.
- R6: With ZERO_INS = 0 and a non-zero seed, the pattern is never all-zeros, and the period of a primitive polynomial is 2^n-1.
- R7: For n = 3, POLY = x^3+x+1, the internal form with insertion and seed 111, the states written as s[0]s[1]s[2] run 111, 101, 100, 010, 001, 000, 110, 011, and then return to 111.
- R8: The internal and external forms built from the same polynomial have the same period but visit the states in a different order.
- R9: Weighted output g covers the bits [g*GRP +: GRP]. It is the AND of those bits when bit g of WT_OR_MASK is 0, and their OR when that bit is 1. Over one full 2^n period, an AND output is 1 in exactly 2^(n-GRP) states and an OR output is 1 in exactly 2^n - 2^(n-GRP) states.
- R10: Every enabled step changes the pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Asynchronous active-high reset that loads SEED |
| step_en_i | input | 1 | Advance the register on this edge |
| pattern_o | output | WIDTH | Current register state, s[0] in bit 0 |
| weighted_o | output | WIDTH/GRP | AND- or OR-folded groups of the pattern |

## Verification
The default 8-bit internal generator runs for a full 256-step period against a model of the next state that uses mask arithmetic. Enable-low runs and irregular enable patterns separate true holding from free running. An external-form copy built from the same polynomial must also close its cycle at 256 steps with no repeated state, and must differ in order at some step, which tells the two feedback forms apart. A 3-bit copy is compared with the known eight-state order, which pins down where the zero word is inserted. A 4-bit copy without insertion must close at 15 steps without ever reaching zero. Exact ones-counts of the weighted outputs over the full period separate an AND group from an OR group and show the grouping of the bits.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  typedef enum logic {FB_EXTERNAL = 1'b0, FB_INTERNAL = 1'b1} fb_style_e;
endpackage

// File: rtl/tpg_next.sv
module tpg_next #(
  parameter int              WIDTH    = 8,
  parameter logic [WIDTH-1:0] POLY    = 8'h63,
  parameter tpg_pkg::fb_style_e FB_STYLE = tpg_pkg::FB_INTERNAL,
  parameter bit              ZERO_INS = 1'b1
) (
  input  logic [WIDTH-1:0] state_i,
  output logic [WIDTH-1:0] next_o,
  output logic             zero_fix_o,
  output logic             fb_o
);
  localparam logic [WIDTH-1:0] TAP_MASK = {1'b1, POLY[WIDTH-1:1]};

  function automatic logic low_clear(input logic [WIDTH-1:0] v);
    return ~|v[WIDTH-2:0];
  endfunction

  function automatic logic tap_parity(input logic [WIDTH-1:0] v);
    return ^(v & TAP_MASK);
  endfunction

  if (ZERO_INS) begin : g_zins
    assign zero_fix_o = low_clear(state_i);
  end else begin : g_nozins
    assign zero_fix_o = 1'b0;
  end

  if (FB_STYLE == tpg_pkg::FB_INTERNAL) begin : g_int
    assign fb_o      = state_i[WIDTH-1] ^ zero_fix_o;
    assign next_o[0] = fb_o;
    for (genvar i = 1; i < WIDTH; i++) begin : g_bit
      assign next_o[i] = state_i[i-1] ^ (POLY[i] & fb_o);
    end
  end else begin : g_ext
    assign fb_o   = tap_parity(state_i) ^ zero_fix_o;
    assign next_o = {state_i[WIDTH-2:0], fb_o};
  end
endmodule

// File: rtl/tpg_state_reg.sv
module tpg_state_reg #(
  parameter int               WIDTH = 8,
  parameter logic [WIDTH-1:0] SEED  = '1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i)     q_o <= SEED;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/tpg_weight.sv
module tpg_weight #(
  parameter int          WIDTH      = 8,
  parameter int          GRP        = 2,
  parameter logic [31:0] WT_OR_MASK = 32'hA
) (
  input  logic [WIDTH-1:0]     bits_i,
  output logic [WIDTH/GRP-1:0] wgt_o
);
  localparam int NGRP = WIDTH / GRP;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    if (WT_OR_MASK[g]) begin : g_or
      assign wgt_o[g] = |bits_i[g*GRP +: GRP];
    end else begin : g_and
      assign wgt_o[g] = &bits_i[g*GRP +: GRP];
    end
  end

  if (NGRP * GRP < WIDTH) begin : g_rest
    logic unused_rest;
    assign unused_rest = ^bits_i[WIDTH-1:NGRP*GRP];
  end
endmodule

// File: rtl/tpg_lfsr_top.sv
module tpg_lfsr_top #(
  parameter int                 WIDTH      = 8,
  parameter logic [WIDTH-1:0]   POLY       = 8'h63,
  parameter tpg_pkg::fb_style_e FB_STYLE   = tpg_pkg::FB_INTERNAL,
  parameter bit                 ZERO_INS   = 1'b1,
  parameter logic [WIDTH-1:0]   SEED       = '1,
  parameter int                 GRP        = 2,
  parameter logic [31:0]        WT_OR_MASK = 32'hA
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 step_en_i,
  output logic [WIDTH-1:0]     pattern_o,
  output logic [WIDTH/GRP-1:0] weighted_o
);
  logic [WIDTH-1:0] next_state;
  logic             zero_fix;
  logic             fb_bit;
  logic             unused_fb;

  assign unused_fb = fb_bit;

  tpg_next #(
    .WIDTH(WIDTH), .POLY(POLY), .FB_STYLE(FB_STYLE), .ZERO_INS(ZERO_INS)
  ) u_next (
    .state_i(pattern_o), .next_o(next_state),
    .zero_fix_o(zero_fix), .fb_o(fb_bit)
  );

  tpg_state_reg #(.WIDTH(WIDTH), .SEED(SEED)) u_reg (
    .clk_i(clk_i), .rst_i(rst_i), .en_i(step_en_i),
    .d_i(next_state), .q_o(pattern_o)
  );

  tpg_weight #(.WIDTH(WIDTH), .GRP(GRP), .WT_OR_MASK(WT_OR_MASK)) u_wgt (
    .bits_i(pattern_o), .wgt_o(weighted_o)
  );
endmodule

// File: rtl/tpg_lfsr_chk.sv
module tpg_lfsr_chk #(
  parameter int                 WIDTH      = 8,
  parameter logic [WIDTH-1:0]   POLY       = 8'h63,
  parameter tpg_pkg::fb_style_e FB_STYLE   = tpg_pkg::FB_INTERNAL,
  parameter bit                 ZERO_INS   = 1'b1,
  parameter logic [WIDTH-1:0]   SEED       = '1,
  parameter int                 GRP        = 2,
  parameter logic [31:0]        WT_OR_MASK = 32'hA
) (
  input logic                 clk_i,
  input logic                 rst_i,
  input logic                 step_en_i,
  input logic [WIDTH-1:0]     pattern_o,
  input logic [WIDTH/GRP-1:0] weighted_o,
  input logic                 zero_fix
);
  localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [WIDTH-1:0] EXIT_ST  =
    (FB_STYLE == tpg_pkg::FB_INTERNAL) ? {POLY[WIDTH-1:1], 1'b1} : {{(WIDTH-1){1'b0}}, 1'b1};

  // R1: seed is present on the first edge after reset falls
  p_seed_r1: assert property (@(posedge clk_i) $fell(rst_i) |-> pattern_o == SEED);

  // R2: disabled edges keep the state
  p_hold_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    !step_en_i |=> $stable(pattern_o) && $stable(weighted_o));

  // R5: the correction term leads into the zero word
  p_zero_entry_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    step_en_i && zero_fix && pattern_o == MSB_ONLY |=> pattern_o == '0);

  // R5: the zero word leads back into the sequence
  p_zero_exit_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    ZERO_INS && step_en_i && pattern_o == '0 |=> pattern_o == EXIT_ST);

  // R6: no lock-up state without insertion
  p_no_zero_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    !ZERO_INS |-> pattern_o != '0);

  // R10: no fixed point
  p_step_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    step_en_i |=> pattern_o != $past(pattern_o));

  for (genvar g = 0; g < WIDTH/GRP; g++) begin : g_wchk
    if (WT_OR_MASK[g]) begin : g_or
      // R9: an OR group reads 0 only when its bits are all clear
      p_or_grp_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        !weighted_o[g] |-> $countones(pattern_o[g*GRP +: GRP]) == 0);
    end else begin : g_and
      // R9: an AND group reads 1 only when its bits are all set
      p_and_grp_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        weighted_o[g] |-> $countones(pattern_o[g*GRP +: GRP]) == GRP);
    end
  end
endmodule

bind tpg_lfsr_top tpg_lfsr_chk #(
  .WIDTH(WIDTH), .POLY(POLY), .FB_STYLE(FB_STYLE), .ZERO_INS(ZERO_INS),
  .SEED(SEED), .GRP(GRP), .WT_OR_MASK(WT_OR_MASK)
) i_chk (
  .clk_i(clk_i), .rst_i(rst_i), .step_en_i(step_en_i),
  .pattern_o(pattern_o), .weighted_o(weighted_o), .zero_fix(zero_fix)
);

// File: tb/test_tpg_lfsr_top.sv
`timescale 1ns/1ps
module test_tpg_lfsr_top;
  localparam logic [7:0] POLY8 = 8'h63;
  localparam logic [7:0] SEED8 = 8'hFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic step_en = 1'b0;
  logic [7:0] p_int, p_ext;
  logic [3:0] w_int, w_ext;
  logic [2:0] p3;
  logic [0:0] w3;
  logic [3:0] p4;
  logic [1:0] w4;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  tpg_lfsr_top i_tpg_lfsr_top (
    .clk_i(clk), .rst_i(rst), .step_en_i(step_en), .pattern_o(p_int), .weighted_o(w_int));

  tpg_lfsr_top #(.FB_STYLE(tpg_pkg::FB_EXTERNAL)) i_ext (
    .clk_i(clk), .rst_i(rst), .step_en_i(step_en), .pattern_o(p_ext), .weighted_o(w_ext));

  tpg_lfsr_top #(.WIDTH(3), .POLY(3'b011), .SEED(3'b111)) i_three (
    .clk_i(clk), .rst_i(rst), .step_en_i(step_en), .pattern_o(p3), .weighted_o(w3));

  tpg_lfsr_top #(.WIDTH(4), .POLY(4'b0011), .FB_STYLE(tpg_pkg::FB_EXTERNAL),
                 .ZERO_INS(1'b0), .SEED(4'b0001)) i_four (
    .clk_i(clk), .rst_i(rst), .step_en_i(step_en), .pattern_o(p4), .weighted_o(w4));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bench-side models, written as mask arithmetic
  function automatic logic [7:0] m_int(input logic [7:0] s);
    logic f;
    logic [7:0] r;
    f = s[7] ^ (s[6:0] == 7'd0);
    r = {s[6:0], f};
    if (f) r = r ^ (POLY8 & 8'hFE);
    return r;
  endfunction

  function automatic logic [7:0] m_ext(input logic [7:0] s);
    logic f;
    f = ^(s & {1'b1, POLY8[7:1]}) ^ (s[6:0] == 7'd0);
    return {s[6:0], f};
  endfunction

  function automatic logic [3:0] m_w(input logic [7:0] s);
    return {s[7] | s[6], s[5] & s[4], s[3] | s[2], s[1] & s[0]};
  endfunction

  // scoreboard
  logic [11:0] exp_q[$];
  string       tag_q[$];
  logic [7:0]  exp_s;

  task automatic tick(input bit en);
    step_en = en;
    if (en) exp_s = m_int(exp_s);
    exp_q.push_back({m_w(exp_s), exp_s});
    tag_q.push_back(en ? "R3" : "R2");
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    #1;
    if (!rst && exp_q.size() > 0) begin
      logic [11:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(p_int == e[7:0], t, p_int, e[7:0]);
      check(w_int == e[11:8], {t, " R9 weighted"}, w_int, e[11:8]);
    end
  end

  // period recorder
  bit rec_on = 0;
  int k = 0;
  bit seen_i[256];
  bit seen_e[256];
  bit seen4[16];
  int dup_i = 0, dup_e = 0, dup4 = 0, zero4 = 0, diff = 0, same = 0;
  int first_i = 0, first_e = 0, first4 = 0;
  bit saw_zero = 0;
  int ones[4] = '{0, 0, 0, 0};
  logic [7:0] me = SEED8;
  logic [7:0] prev_int = SEED8;
  logic [2:0] lit[8] = '{3'b111, 3'b101, 3'b100, 3'b010, 3'b001, 3'b000, 3'b110, 3'b011};

  always @(posedge clk) begin
    #1;
    if (rec_on) begin
      k++;
      if (seen_i[p_int]) dup_i++;
      seen_i[p_int] = 1'b1;
      if (p_int == SEED8 && first_i == 0) first_i = k;
      if (p_int == 8'h00) saw_zero = 1'b1;
      for (int g = 0; g < 4; g++) ones[g] += int'(w_int[g]);
      if (p_int == prev_int) same++;
      prev_int = p_int;
      me = m_ext(me);
      check(p_ext == me, "R4", p_ext, me);
      if (seen_e[p_ext]) dup_e++;
      seen_e[p_ext] = 1'b1;
      if (p_ext == SEED8 && first_e == 0) first_e = k;
      if (p_ext != p_int) diff++;
      if (k <= 8) check({p3[0], p3[1], p3[2]} == lit[k % 8], "R7",
                        {p3[0], p3[1], p3[2]}, lit[k % 8]);
      if (k <= 15) begin
        if (p4 == 4'd0) zero4++;
        if (seen4[p4]) dup4++;
        seen4[p4] = 1'b1;
      end
      if (p4 == 4'b0001 && first4 == 0) first4 = k;
    end
  end

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    exp_s = SEED8;
    repeat (3) @(negedge clk);
    check(p_int == SEED8, "R1 reset int", p_int, SEED8);
    check(p_ext == SEED8, "R1 reset ext", p_ext, SEED8);
    check(p3 == 3'b111, "R1 reset three", p3, 3'b111);
    check(p4 == 4'b0001, "R1 reset four", p4, 4'b0001);
    rst = 1'b0;
    repeat (3) tick(1'b0);
    rec_on = 1'b1;
    repeat (256) tick(1'b1);
    rec_on = 1'b0;
    step_en = 1'b0;
    @(negedge clk);
    check(first_i == 256, "R5 period int", first_i, 256);
    check(dup_i == 0, "R5 distinct int", dup_i, 0);
    check(saw_zero, "R5 zero visited", saw_zero, 1);
    check(first_e == 256, "R8 period ext", first_e, 256);
    check(dup_e == 0, "R8 distinct ext", dup_e, 0);
    check(diff > 0, "R8 order differs", diff, 1);
    check(first4 == 15, "R6 period four", first4, 15);
    check(zero4 == 0, "R6 no zero", zero4, 0);
    check(dup4 == 0, "R6 distinct four", dup4, 0);
    check(same == 0, "R10 every step moves", same, 0);
    check(ones[0] == 64, "R9 and group 0", ones[0], 64);
    check(ones[1] == 192, "R9 or group 1", ones[1], 192);
    check(ones[2] == 64, "R9 and group 2", ones[2], 64);
    check(ones[3] == 192, "R9 or group 3", ones[3], 192);
    // mid-run reset
    repeat (5) tick(1'b1);
    step_en = 1'b1;
    rst = 1'b1;
    @(posedge clk); #1;
    check(p_int == SEED8, "R1 mid-run int", p_int, SEED8);
    check(p4 == 4'b0001, "R1 mid-run four", p4, 4'b0001);
    @(negedge clk);
    step_en = 1'b0;
    rst = 1'b0;
    exp_s = SEED8;
    // irregular enable
    for (int i = 0; i < 40; i++) tick((i % 3) != 0);
    repeat (2) tick(1'b0);
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule